// File: doc/BRIEF.md
# Time-Base Bit-Tap Interval Timer

This block produces a periodic interval event from a free-running 64-bit time-base value that it receives from outside. It does not count reload values. It selects one bit of the time base and fires when that bit goes from 0 to 1. So the interval is always a power of two of time-base ticks. The bit is selected by a 6-bit period code. The code is built from a 2-bit basic field and a 4-bit extension field, both held in a 32-bit timer control word.

Each event sets a sticky status flag. Software clears the flag by writing ones to the status word. The interrupt line is the flag gated by an enable bit in the control word. When software writes a new period code, the edge history is taken again from the newly selected bit, so retargeting the tap does not cause a false event.

Top module: `tbtap_interval_timer`

## Requirements
- R1: The tapped time-base bit index is 63 minus the 6-bit code {ctl[16:13], ctl[25:24]}. Control bits 16:13 are the upper four bits of the code and bits 25:24 are the lower two.
- R2: An event occurs in a cycle where the tapped bit is 1 and its sample from the previous cycle was 0. No event occurs in the first cycle after reset. With a time base that increments by one each cycle, events repeat every 2^(index+1) cycles.
- R3: An event sets status bit 26 at the next clock edge. The bit then stays 1 until software clears it.
- R4: irq_o is 1 exactly when status bit 26 and control bit 23 are both 1.
- R5: A status write clears every status bit whose written value is 1. Status bits written as 0 keep their value.
- R6: While reset is active, the control word reads 0, the status word reads 0 and irq_o is 0.
- R7: A control write loads the edge history from the bit that the new word selects. A newly selected bit that is already 1 therefore raises no event in the cycle after the write.
- R8: If an event and a write-one-to-clear of bit 26 happen in the same cycle, bit 26 ends up 1.
- R9: A control write stores the whole 32-bit word, and ctl_o shows it from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tbase_i | input | 64 | Free-running time-base value |
| ctl_we_i | input | 1 | Control word write strobe |
| ctl_wdata_i | input | 32 | Control word write data |
| sts_we_i | input | 1 | Status write strobe (write one to clear) |
| sts_wdata_i | input | 32 | Status clear mask |
| ctl_o | output | 32 | Current control word |
| sts_o | output | 32 | Current status word (bit 26 is the interval flag) |
| irq_o | output | 1 | Interval interrupt request |

## Verification
The assertions assume that the write strobes and data are defined in every cycle after reset. They also assume that the time base can take any value from one cycle to the next, so nothing is assumed about how it counts. The stimulus mixes time-base segments that count by one with random jumps. It writes control words whose extension field is mostly all ones, which keeps the tapped bit low and makes events frequent. Directed cases cover a retarget onto a bit that is already set, an event and a clear in the same cycle, and a high tap reached by a jump.

// File: rtl/tbtap_pkg.sv
package tbtap_pkg;
   // How the period code is assembled from the control word.
   typedef enum logic {
      TAP_CODE_BASIC    = 1'b0,  // only the 2-bit basic field
      TAP_CODE_EXTENDED = 1'b1   // extension field concatenated above it
   } tap_code_mode_e;

   localparam int unsigned TBTAP_FP_W  = 2;
   localparam int unsigned TBTAP_EXT_W = 4;
endpackage

// File: rtl/tbtap_index.sv
module tbtap_index
   import tbtap_pkg::*;
#(
   parameter int unsigned    TB_W  = 64,
   parameter int unsigned    FP_W  = TBTAP_FP_W,
   parameter int unsigned    EXT_W = TBTAP_EXT_W,
   parameter tap_code_mode_e MODE  = TAP_CODE_EXTENDED,
   parameter int unsigned    IDX_W = $clog2(TB_W)
) (
   input  logic [FP_W-1:0]  fp_code,
   input  logic [EXT_W-1:0] ext_code,
   output logic [IDX_W-1:0] tap_idx
);
   localparam int unsigned CODE_W = FP_W + EXT_W;
   localparam logic [IDX_W-1:0] TOP_IDX = IDX_W'(TB_W - 1);

   logic [CODE_W-1:0] code;

   if (CODE_W > IDX_W) begin : g_bad_code
      $error("period code wider than time-base index");
   end

   if (MODE == TAP_CODE_EXTENDED) begin : g_ext
      assign code = {ext_code, fp_code};
   end else begin : g_basic
      logic ext_unused;
      assign ext_unused = ^ext_code;
      assign code = {{EXT_W{ext_unused & 1'b0}}, fp_code};
   end

   assign tap_idx = TOP_IDX - IDX_W'(code);
endmodule

// File: rtl/tbtap_edge.sv
module tbtap_edge #(
   parameter int unsigned TB_W  = 64,
   parameter int unsigned IDX_W = $clog2(TB_W)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [TB_W-1:0]  tbase_i,
   input  logic [IDX_W-1:0] cur_idx,
   input  logic             load,
   input  logic [IDX_W-1:0] load_idx,
   output logic             tap_bit,
   output logic             evt
);
   logic prev_q;
   logic vld_q;

   assign tap_bit = tbase_i[cur_idx];
   assign evt     = vld_q & ~prev_q & tap_bit;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         prev_q <= 1'b0;
         vld_q  <= 1'b0;
      end else begin
         vld_q  <= 1'b1;
         // a retarget takes its history from the newly selected bit
         prev_q <= load ? tbase_i[load_idx] : tap_bit;
      end
   end
endmodule

// File: rtl/tbtap_status.sv
module tbtap_status #(
   parameter int unsigned CW      = 32,
   parameter int unsigned EVT_BIT = 26
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          evt,
   input  logic          we,
   input  logic [CW-1:0] wmask,
   output logic [CW-1:0] sts_q
);
   logic [CW-1:0] set_vec;
   logic [CW-1:0] clr_vec;

   always_comb begin
      set_vec          = '0;
      set_vec[EVT_BIT] = evt;
      clr_vec          = we ? wmask : '0;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) sts_q <= '0;
      else        sts_q <= (sts_q & ~clr_vec) | set_vec;  // set wins
   end
endmodule

// File: rtl/tbtap_interval_timer.sv
module tbtap_interval_timer
   import tbtap_pkg::*;
#(
   parameter int unsigned    TB_W    = 64,
   parameter int unsigned    CW      = 32,
   parameter int unsigned    FP_LSB  = 24,
   parameter int unsigned    EXT_LSB = 13,
   parameter int unsigned    EN_BIT  = 23,
   parameter int unsigned    EVT_BIT = 26,
   parameter tap_code_mode_e MODE    = TAP_CODE_EXTENDED
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [63:0]   tbase_i,
   input  logic          ctl_we_i,
   input  logic [31:0]   ctl_wdata_i,
   input  logic          sts_we_i,
   input  logic [31:0]   sts_wdata_i,
   output logic [31:0]   ctl_o,
   output logic [31:0]   sts_o,
   output logic          irq_o
);
   localparam int unsigned IDX_W = $clog2(TB_W);
   localparam int unsigned FP_W  = TBTAP_FP_W;
   localparam int unsigned EXT_W = TBTAP_EXT_W;

   if (TB_W != 64 || CW != 32) begin : g_bad_width
      $error("port widths fixed at 64-bit time base and 32-bit words");
   end
   if (FP_LSB + FP_W > CW || EXT_LSB + EXT_W > CW || EN_BIT >= CW || EVT_BIT >= CW) begin : g_bad_field
      $error("control or status field outside the word");
   end

   logic [CW-1:0]    ctl_q;
   logic [IDX_W-1:0] idx_cur;
   logic [IDX_W-1:0] idx_new;
   logic             tap_now;
   logic             evt_pulse;
   logic [CW-1:0]    sts_q;

   always_ff @(posedge clk) begin
      if (!rst_n)        ctl_q <= '0;
      else if (ctl_we_i) ctl_q <= ctl_wdata_i;
   end

   tbtap_index #(.TB_W(TB_W), .FP_W(FP_W), .EXT_W(EXT_W), .MODE(MODE), .IDX_W(IDX_W)) u_idx_cur (
      .fp_code  (ctl_q[FP_LSB +: FP_W]),
      .ext_code (ctl_q[EXT_LSB +: EXT_W]),
      .tap_idx  (idx_cur)
   );

   tbtap_index #(.TB_W(TB_W), .FP_W(FP_W), .EXT_W(EXT_W), .MODE(MODE), .IDX_W(IDX_W)) u_idx_new (
      .fp_code  (ctl_wdata_i[FP_LSB +: FP_W]),
      .ext_code (ctl_wdata_i[EXT_LSB +: EXT_W]),
      .tap_idx  (idx_new)
   );

   tbtap_edge #(.TB_W(TB_W), .IDX_W(IDX_W)) u_edge (
      .clk      (clk),
      .rst_n    (rst_n),
      .tbase_i  (tbase_i),
      .cur_idx  (idx_cur),
      .load     (ctl_we_i),
      .load_idx (idx_new),
      .tap_bit  (tap_now),
      .evt      (evt_pulse)
   );

   tbtap_status #(.CW(CW), .EVT_BIT(EVT_BIT)) u_sts (
      .clk   (clk),
      .rst_n (rst_n),
      .evt   (evt_pulse),
      .we    (sts_we_i),
      .wmask (sts_wdata_i),
      .sts_q (sts_q)
   );

   assign ctl_o = ctl_q;
   assign sts_o = sts_q;
   assign irq_o = sts_q[EVT_BIT] & ctl_q[EN_BIT];
endmodule

// File: rtl/tbtap_interval_timer_chk.sv
module tbtap_interval_timer_chk #(
   parameter int unsigned EN_BIT  = 23,
   parameter int unsigned EVT_BIT = 26
) (
   input logic        clk,
   input logic        rst_n,
   input logic        ctl_we_i,
   input logic [31:0] ctl_wdata_i,
   input logic        sts_we_i,
   input logic [31:0] sts_wdata_i,
   input logic [31:0] ctl_o,
   input logic [31:0] sts_o,
   input logic        irq_o,
   input logic        evt,
   input logic        tap_bit
);
   // R4
   irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o == (sts_o[EVT_BIT] & ctl_o[EN_BIT]));

   // R3
   flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sts_o[EVT_BIT] && !(sts_we_i && sts_wdata_i[EVT_BIT])) |=> sts_o[EVT_BIT]);

   // R8
   evt_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
      evt |=> sts_o[EVT_BIT]);

   // R5
   w1c_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sts_we_i && sts_wdata_i[EVT_BIT] && !evt) |=> !sts_o[EVT_BIT]);

   // R2
   evt_on_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
      evt |-> tap_bit);

   // R9
   ctl_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ctl_we_i |=> ctl_o == $past(ctl_wdata_i));
endmodule

bind tbtap_interval_timer tbtap_interval_timer_chk #(.EN_BIT(EN_BIT), .EVT_BIT(EVT_BIT)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .ctl_we_i    (ctl_we_i),
   .ctl_wdata_i (ctl_wdata_i),
   .sts_we_i    (sts_we_i),
   .sts_wdata_i (sts_wdata_i),
   .ctl_o       (ctl_o),
   .sts_o       (sts_o),
   .irq_o       (irq_o),
   .evt         (evt_pulse),
   .tap_bit     (tap_now)
);

// File: tb/tbtap_interval_timer_bench.sv
module tbtap_interval_timer_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [63:0] tbase = '0;
   logic        ctl_we = 1'b0;
   logic [31:0] ctl_wd = '0;
   logic        sts_we = 1'b0;
   logic [31:0] sts_wd = '0;
   logic [31:0] ctl_o;
   logic [31:0] sts_o;
   logic        irq_o;

   int checks = 0;
   int fails  = 0;
   bit done   = 0;

   // reference state
   logic [31:0] m_ctl;
   logic        m_flag, m_prev, m_vld;

   always #2.5 clk = ~clk;  // 200 MHz

   tbtap_interval_timer u_tbtap_interval_timer (
      .clk(clk), .rst_n(rst_n), .tbase_i(tbase),
      .ctl_we_i(ctl_we), .ctl_wdata_i(ctl_wd),
      .sts_we_i(sts_we), .sts_wdata_i(sts_wd),
      .ctl_o(ctl_o), .sts_o(sts_o), .irq_o(irq_o)
   );

   // R1: index = 63 - {ctl[16:13], ctl[25:24]}
   function automatic int tap_of(logic [31:0] w);
      return 63 - int'({w[16:13], w[25:24]});
   endfunction

   function automatic logic [31:0] mk_ctl(logic [3:0] ext, logic [1:0] fp, logic en);
      logic [31:0] w = '0;
      w[16:13] = ext; w[25:24] = fp; w[23] = en;
      return w;
   endfunction

   task automatic chk(bit ok, string req, logic [63:0] act, logic [63:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // advance one clock; the reference model applies the same inputs
   task automatic tick();
      logic cur, ev;
      cur = tbase[tap_of(m_ctl)];
      ev  = m_vld & ~m_prev & cur;
      m_flag = ev | (m_flag & ~(sts_we & sts_wd[26]));
      m_prev = ctl_we ? tbase[tap_of(ctl_wd)] : cur;
      if (ctl_we) m_ctl = ctl_wd;
      m_vld = 1'b1;
      @(posedge clk);
      @(negedge clk);
      ctl_we = 1'b0;
      sts_we = 1'b0;
      chk(sts_o == {5'b0, m_flag, 26'b0}, "R2/R3 status", sts_o, {5'b0, m_flag, 26'b0});
      chk(irq_o == (m_flag & m_ctl[23]), "R4 irq", irq_o, m_flag & m_ctl[23]);
      chk(ctl_o == m_ctl, "R9 ctl", ctl_o, m_ctl);
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog expired actual=1 expected=0");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin : main
      int evcount;
      void'($urandom(32'd4242));
      m_ctl = '0; m_flag = 0; m_prev = 0; m_vld = 0;
      repeat (3) @(negedge clk);
      // R6: reset values
      chk(ctl_o == 0, "R6 ctl reset", ctl_o, 0);
      chk(sts_o == 0, "R6 sts reset", sts_o, 0);
      chk(irq_o == 0, "R6 irq reset", irq_o, 0);
      rst_n = 1'b1;
      tbase = 64'h1;
      tick();
      // R7: retarget onto bit 0 that is already 1 -> no event
      ctl_we = 1; ctl_wd = mk_ctl(4'hF, 2'd3, 1'b0);
      tick();
      tick();
      chk(sts_o[26] == 1'b0, "R7 no spurious event", sts_o[26], 0);
      // R2/R3: rising bit 0
      tbase = 64'h2; tick();
      tbase = 64'h3; tick();
      chk(sts_o[26] == 1'b1, "R2 rise sets flag", sts_o[26], 1);
      tick(); tick();
      chk(sts_o[26] == 1'b1, "R3 flag sticky", sts_o[26], 1);
      chk(irq_o == 1'b0, "R4 irq masked", irq_o, 0);
      ctl_we = 1; ctl_wd = mk_ctl(4'hF, 2'd3, 1'b1); tick();
      chk(irq_o == 1'b1, "R4 irq enabled", irq_o, 1);
      // R5: zero in bit 26 leaves it, one clears it
      sts_we = 1; sts_wd = 32'hFBFF_FFFF; tick();
      chk(sts_o[26] == 1'b1, "R5 zero bit kept", sts_o[26], 1);
      sts_we = 1; sts_wd = 32'h0400_0000; tick();
      chk(sts_o[26] == 1'b0, "R5 one bit cleared", sts_o[26], 0);
      // R8: event and clear together
      tbase = 64'h4; tick();
      tbase = 64'h5; sts_we = 1; sts_wd = 32'hFFFF_FFFF; tick();
      chk(sts_o[26] == 1'b1, "R8 set wins", sts_o[26], 1);
      // R1/R2: tap index 2 (code 61), counting time base -> period 8
      tbase = 64'h0; ctl_we = 1; ctl_wd = mk_ctl(4'hF, 2'd1, 1'b1);
      sts_we = 1; sts_wd = 32'h0400_0000; tick();
      evcount = 0;
      for (int k = 1; k <= 64; k++) begin
         tbase = 64'(k);
         if (sts_o[26]) begin
            evcount++;
            sts_we = 1; sts_wd = 32'h0400_0000;
         end
         tick();
      end
      if (sts_o[26]) evcount++;
      chk(evcount == 8, "R2 period of index 2", evcount, 8);
      // R1: code 56 -> index 7
      sts_we = 1; sts_wd = 32'hFFFF_FFFF;
      ctl_we = 1; ctl_wd = mk_ctl(4'hE, 2'd0, 1'b1); tbase = 64'h7F; tick();
      tbase = 64'h80; tick();
      chk(sts_o[26] == 1'b1, "R1 bit 7 tapped", sts_o[26], 1);
      sts_we = 1; sts_wd = 32'h0400_0000; tbase = 64'h100; tick();
      chk(sts_o[26] == 1'b0, "R1 bit 7 fall no event", sts_o[26], 0);
      // random phase
      for (int n = 0; n < 4000; n++) begin
         if ($urandom_range(0, 7) == 0) tbase = {$urandom, $urandom};
         else tbase = tbase + 64'd1;
         if ($urandom_range(0, 31) == 0) begin
            ctl_we = 1; ctl_wd = $urandom;
            if ($urandom_range(0, 3) != 0) ctl_wd[16:13] = 4'hF;
         end
         if ($urandom_range(0, 5) == 0) begin
            sts_we = 1; sts_wd = $urandom;
         end
         tick();
      end
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule